// File: doc/BRIEF.md
# Two-Pass 8x8 Hadamard Transform

This block turns an 8x8 tile of signed 16-bit residual samples into 64 Hadamard coefficients. Rows of eight samples arrive over a valid/ready stream. Each accepted row goes at once through a three-stage 8-point butterfly network, and the result is kept in a local 8x8 register array. Once the eighth row is in, the block switches to draining. Each output row is made by running the same butterfly over one column of the stored intermediate. This equals a transform over the columns, a transpose, and a second transform, with no transpose at the end. Coefficients leave as eight rows in row-major order over a second valid/ready stream.

Parameter `WIDE` selects the arithmetic width:
- With `WIDE=0`, every lane is 16-bit two's complement and wraps on overflow.
- With `WIDE=1`, inputs are sign-extended to `WIDE_W` (32) bits before the first addition, and the results are exact.

No shift, rounding or scaling is applied at any point.

Back-pressure rules:
- An input beat transfers when `in_valid` and `in_ready` are both high.
- An output beat transfers when `out_valid` and `out_ready` are both high.
- `in_ready` is low from the cycle after the eighth row is accepted until the last output row has been taken.
- While `out_ready` is low, the offered output row stays unchanged.

Top module: `hadamard8x8`

## Requirements
- R1: After a synchronous active-high reset, `in_ready` is 1 and `out_valid` is 0.
- R2: Input lane c occupies `in_data[16c+15:16c]`. The first accepted beat of a tile is row 0 and the eighth is row 7.
- R3: `in_ready` and `out_valid` are never both high. `out_valid` rises in the cycle after the eighth input row is accepted. `in_ready` returns in the cycle after the eighth output row is accepted.
- R4: Output beat j (j=0..7) carries lane k at `out_data[LW*k+LW-1:LW*k]`, equal to sum over r,c of S(k,r)·S(j,c)·x[r][c]. Here x[r][c] is lane c of input row r, S(u,v) = (-1)^popcount(m(u) AND v), and m = (0,6,4,2,3,7,5,1).
- R5: The 8-point butterfly has three stages:
  - First, sums and differences of lane pairs (0,1), (2,3), (4,5), (6,7).
  - Second, within each half, element i paired with element i+2.
  - Third, sums of i and i+4 go to lanes 0,7,3,4 for i=0..3, and the matching differences go to lanes 2,6,1,5.
- R6: No right shift or rounding is applied. A tile with every sample equal to v yields 64v in row 0 lane 0 and 0 in every other lane.
- R7: With `WIDE=0`, each output lane is the R4 value taken modulo 2^16, in two's complement.
- R8: With `WIDE=1`, inputs are sign-extended to 32 bits and each output lane equals the R4 value exactly.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` stays unchanged on the next cycle.
- R10: Input beats offered while `in_ready` is 0 are not captured and do not change the following tile's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input row offered |
| in_ready | output | 1 | Block can accept an input row |
| in_data | input | 8*IN_W | Eight signed input samples, lane c at bits [IN_W*c +: IN_W] |
| out_valid | output | 1 | Coefficient row offered |
| out_ready | input | 1 | Downstream takes the coefficient row |
| out_data | output | 8*LW | Eight coefficients, LW = WIDE ? WIDE_W : IN_W |

## Verification
Single-sample impulses at different row and column positions separate lane ordering and the output permutation. A wrong sign or a swapped output lane shows up as one misplaced ±1. Constant tiles show that no scaling is applied, since all energy must land in coefficient (0,0). Random small tiles check full agreement with the matrix formula. Full-scale tiles, fed to a narrow and a wide instance side by side, tell 16-bit wrapping apart from exact 32-bit sums. Random output stalls and junk input offered during draining check the handshake rules.

// File: rtl/hd_pkg.sv
package hd_pkg;
  localparam int LANES = 8;
  localparam int CW    = $clog2(LANES);

  typedef enum logic {ST_LOAD, ST_DRAIN} hd_state_e;

  // third-stage destination lane for the sum of element i and i+4
  function automatic int sum_dst(input int i);
    case (i)
      0: return 0;
      1: return 7;
      2: return 3;
      default: return 4;
    endcase
  endfunction

  // third-stage destination lane for the difference of element i and i+4
  function automatic int dif_dst(input int i);
    case (i)
      0: return 2;
      1: return 6;
      2: return 1;
      default: return 5;
    endcase
  endfunction
endpackage

// File: rtl/hd_butterfly.sv
module hd_butterfly import hd_pkg::*; #(
  parameter int W = 16
) (
  input  logic [LANES*W-1:0] din,
  output logic [LANES*W-1:0] dout
);
  logic [W-1:0] x  [LANES];
  logic [W-1:0] s1 [LANES];
  logic [W-1:0] s2 [LANES];
  logic [W-1:0] y  [LANES];

  for (genvar i = 0; i < LANES; i++) begin : g_io
    assign x[i] = din[i*W +: W];
    assign dout[i*W +: W] = y[i];
  end

  // stage one: adjacent pairs
  for (genvar p = 0; p < LANES/2; p++) begin : g_st1
    assign s1[2*p]   = x[2*p] + x[2*p+1];
    assign s1[2*p+1] = x[2*p] - x[2*p+1];
  end

  // stage two: distance two inside each half
  for (genvar g = 0; g < 2; g++) begin : g_st2
    localparam int B = 4*g;
    assign s2[B]   = s1[B]   + s1[B+2];
    assign s2[B+1] = s1[B+1] + s1[B+3];
    assign s2[B+2] = s1[B]   - s1[B+2];
    assign s2[B+3] = s1[B+1] - s1[B+3];
  end

  // stage three: distance four, permuted destinations
  for (genvar i = 0; i < LANES/2; i++) begin : g_st3
    localparam int SD = sum_dst(i);
    localparam int DD = dif_dst(i);
    assign y[SD] = s2[i] + s2[i+4];
    assign y[DD] = s2[i] - s2[i+4];
  end
endmodule

// File: rtl/hd_tile.sv
module hd_tile import hd_pkg::*; #(
  parameter int W = 16
) (
  input  logic               clk,
  input  logic               wr_en,
  input  logic [CW-1:0]      wr_row,
  input  logic [LANES*W-1:0] wr_data,
  input  logic [CW-1:0]      rd_col,
  output logic [LANES*W-1:0] rd_data
);
  logic [W-1:0] mem [LANES][LANES];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int c = 0; c < LANES; c++) mem[wr_row][c] <= wr_data[c*W +: W];
    end
  end

  // column read: lane r of the result is row r of the chosen column
  for (genvar r = 0; r < LANES; r++) begin : g_rd
    assign rd_data[r*W +: W] = mem[r][rd_col];
  end
endmodule

// File: rtl/hadamard8x8.sv
module hadamard8x8 import hd_pkg::*; #(
  parameter int IN_W   = 16,
  parameter int WIDE_W = 32,
  parameter int WIDE   = 0
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               in_valid,
  output logic                               in_ready,
  input  logic [LANES*IN_W-1:0]              in_data,
  output logic                               out_valid,
  input  logic                               out_ready,
  output logic [LANES*((WIDE != 0) ? WIDE_W : IN_W)-1:0] out_data
);
  localparam int LW = (WIDE != 0) ? WIDE_W : IN_W;

  hd_state_e         state;
  logic [CW-1:0]     in_row, out_row;
  logic              in_fire, out_fire;
  logic [LANES*LW-1:0] ext_in, col_data, bf_in, bf_out;

  assign in_ready  = (state == ST_LOAD);
  assign out_valid = (state == ST_DRAIN);
  assign in_fire   = in_valid && in_ready;
  assign out_fire  = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_LOAD;
      in_row  <= '0;
      out_row <= '0;
    end else begin
      case (state)
        ST_LOAD: if (in_fire) begin
          in_row <= in_row + 1'b1;
          if (in_row == CW'(LANES-1)) state <= ST_DRAIN;
        end
        default: if (out_fire) begin
          out_row <= out_row + 1'b1;
          if (out_row == CW'(LANES-1)) state <= ST_LOAD;
        end
      endcase
    end
  end

  // lane widening picked by parameter
  for (genvar i = 0; i < LANES; i++) begin : g_ext
    if (WIDE != 0) begin : g_wide
      assign ext_in[i*LW +: LW] =
        {{(LW-IN_W){in_data[i*IN_W+IN_W-1]}}, in_data[i*IN_W +: IN_W]};
    end else begin : g_narrow
      assign ext_in[i*LW +: LW] = in_data[i*IN_W +: IN_W];
    end
  end

  // one butterfly serves both passes: rows while loading, columns while draining
  assign bf_in = (state == ST_LOAD) ? ext_in : col_data;

  hd_butterfly #(.W(LW)) u_bf (
    .din  (bf_in),
    .dout (bf_out)
  );

  hd_tile #(.W(LW)) u_tile (
    .clk     (clk),
    .wr_en   (in_fire),
    .wr_row  (in_row),
    .wr_data (bf_out),
    .rd_col  (out_row),
    .rd_data (col_data)
  );

  assign out_data = bf_out;
endmodule

// File: rtl/hadamard8x8_chk.sv
module hadamard8x8_chk import hd_pkg::*; #(
  parameter int W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [LANES*W-1:0] out_data
);
  logic [CW:0] pend;
  logic [CW:0] got;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      got  <= '0;
    end else begin
      if (in_valid && in_ready) begin
        if (got == (CW+1)'(LANES-1)) begin
          got  <= '0;
          pend <= (CW+1)'(LANES);
        end else begin
          got <= got + 1'b1;
        end
      end
      if (out_valid && out_ready) pend <= pend - 1'b1;
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (in_ready && !out_valid));

  // R3
  excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(in_ready && out_valid));

  // R3
  drain_pending_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (pend != '0));

  // R3
  load_empty_chk: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> (pend == '0));

  // R3
  drain_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(in_valid && in_ready));

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

bind hadamard8x8 hadamard8x8_chk #(.W(LW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/tb_hadamard8x8.sv
`timescale 1ns/1ps
module tb_hadamard8x8;
  logic clk = 0;
  logic rst = 1;
  logic in_valid = 0;
  logic [127:0] in_data = '0;
  logic out_ready = 1;
  logic n_in_ready, n_out_valid, w_in_ready, w_out_valid;
  logic [127:0] n_out_data;
  logic [255:0] w_out_data;

  always #2 clk = ~clk;  // 250 MHz

  hadamard8x8 #(.WIDE(0)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(n_in_ready),
    .in_data(in_data), .out_valid(n_out_valid), .out_ready(out_ready),
    .out_data(n_out_data));

  hadamard8x8 #(.WIDE(1)) dut_wide (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(w_in_ready),
    .in_data(in_data), .out_valid(w_out_valid), .out_ready(out_ready),
    .out_data(w_out_data));

  int n_cmp = 0, n_bad = 0, cyc = 0;
  string cur_tag = "R2";
  bit bp_mode = 0;

  int stim [8][8];
  int xin  [8][8];
  int expv [8][8];
  bit m_drain = 0, m_last_in = 0;
  int m_in_row = 0, m_out_row = 0;

  function automatic int sgn(input int u, input int v);
    int mp [8] = '{0, 6, 4, 2, 3, 7, 5, 1};
    return ($countones(mp[u] & v) % 2 == 1) ? -1 : 1;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (time %0t)", tag, act, exp, $time);
    end
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    cyc++;
    m_last_in = 0;
    if (rst) begin
      m_drain = 0; m_in_row = 0; m_out_row = 0;
    end else if (!m_drain) begin
      if (in_valid) begin
        for (int c = 0; c < 8; c++) xin[m_in_row][c] = int'($signed(in_data[16*c +: 16]));
        m_last_in = 1;
        m_in_row++;
        if (m_in_row == 8) begin
          for (int j = 0; j < 8; j++)
            for (int k = 0; k < 8; k++) begin
              expv[j][k] = 0;
              for (int r = 0; r < 8; r++)
                for (int c = 0; c < 8; c++)
                  expv[j][k] += sgn(k, r) * sgn(j, c) * xin[r][c];
            end
          m_in_row = 0;
          m_drain = 1;
        end
      end
    end else if (out_ready) begin
      m_out_row++;
      if (m_out_row == 8) begin
        m_out_row = 0;
        m_drain = 0;
      end
    end
  end

  // comparison on every falling edge, then drive out_ready
  always @(negedge clk) begin
    if (!rst) begin
      check("R3", {31'b0, n_in_ready},  {31'b0, !m_drain});
      check("R3", {31'b0, n_out_valid}, {31'b0, m_drain});
      check("R8", {31'b0, w_out_valid}, {31'b0, m_drain});
      if (m_drain && n_out_valid) begin
        for (int k = 0; k < 8; k++) begin
          logic [31:0] e32;
          e32 = expv[m_out_row][k];
          check(cur_tag, {16'b0, n_out_data[16*k +: 16]}, {16'b0, e32[15:0]});  // narrow wraps (R7)
          check("R8", w_out_data[32*k +: 32], e32);
        end
      end
    end
    out_ready = bp_mode ? 1'($urandom_range(0, 1)) : 1'b1;
  end

  always @(posedge clk) begin
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL R3 watchdog: actual %0d cycles expected fewer than 100000", cyc);
      summary();
    end
  end

  task automatic send_block(input string tag, input bit junk);
    while (m_drain) @(negedge clk);
    cur_tag = tag;
    for (int r = 0; r < 8; r++) begin
      in_valid = 1;
      for (int c = 0; c < 8; c++) in_data[16*c +: 16] = 16'(stim[r][c]);
      do @(negedge clk); while (!m_last_in);
    end
    if (junk) begin
      // R10: offer junk while the block is draining
      in_valid = 1;
      while (m_drain) begin
        in_data = {$urandom, $urandom, $urandom, $urandom};
        @(negedge clk);
      end
    end
    in_valid = 0;
  endtask

  task automatic fill(input int v);
    for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++) stim[r][c] = v;
  endtask

  task automatic fill_rand(input int lo, input int hi);
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++) stim[r][c] = int'($urandom_range(0, hi - lo)) + lo;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: idle after reset
    check("R1", {31'b0, n_in_ready},  32'd1);
    check("R1", {31'b0, n_out_valid}, 32'd0);

    // R2: lane and row placement via impulses
    fill(0); stim[0][0] = 1;  send_block("R2", 0);
    fill(0); stim[0][3] = 1;  send_block("R2", 0);
    fill(0); stim[4][0] = -1; send_block("R2", 0);

    // R5: butterfly stages and output permutation
    fill(0); stim[5][2] = 1; send_block("R5", 0);
    fill(0); stim[7][7] = 3; send_block("R5", 0);
    fill(0); stim[2][6] = 1; stim[6][1] = -2; send_block("R5", 0);

    // R6: constant tiles, no scaling
    fill(100); send_block("R6", 0);
    fill(-7);  send_block("R6", 0);

    // R4: random residual-range tiles
    for (int i = 0; i < 4; i++) begin fill_rand(-255, 255); send_block("R4", 0); end

    // R7: full-scale tiles force 16-bit wrap
    fill(32767);  send_block("R7", 0);
    fill(-32768); send_block("R7", 0);
    for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++)
      stim[r][c] = ((r + c) % 2 == 0) ? 32767 : -32768;
    send_block("R7", 0);

    // R9: random output stalls
    bp_mode = 1;
    for (int i = 0; i < 3; i++) begin fill_rand(-32768, 32767); send_block("R9", 0); end

    // R10: junk offered during draining
    for (int i = 0; i < 2; i++) begin fill_rand(-300, 300); send_block("R10", 1); end
    bp_mode = 0;
    fill_rand(-255, 255); send_block("R10", 0);

    while (m_drain) @(negedge clk);
    repeat (4) @(negedge clk);
    summary();
  end
endmodule